// File: doc/BRIEF.md
# Dual-Width Effective Address Unit

This unit turns a logical address from the core into the physical bus address for a processor that runs in two addressing forms. In the wide form a 24-bit logical address goes to the bus unchanged. In the paged form only the low 16 bits of the logical address count, and an 8-bit page register supplies bits 23:16 of the bus address. Whatever the upper byte of the logical address holds, the paged form ignores it.

A persistent long-mode bit chooses the default form. An instruction can override that default with two bits of its own. One bit covers data and stack operands and the other covers instruction fetches. The unit also reports how many bytes a stack push or pop moves. When an instruction retires it can update the persistent mode: a call, return or restart that runs with a wide fetch width sets the long-mode bit. The address and byte-count outputs are combinational. The long-mode bit is a register that changes only on a retiring clock edge.

Top module: `eaddr_unit`

## Requirements
- R1: When the width chosen for the current access is wide (1), `eff_addr` equals all 24 bits of `lg_addr`.
- R2: When the width chosen for the current access is paged (0), `eff_addr[23:16]` equals `page_reg` and `eff_addr[15:0]` equals `lg_addr[15:0]`. The value of `lg_addr[23:16]` has no effect on `eff_addr`.
- R3: Access kind code 0 is a fetch and uses the fetch width. Code 1 (data) and code 2 (stack) use the data width.
- R4: When `ovr_valid` is 0, the data width and the fetch width both equal the current `long_mode`. When `ovr_valid` is 1, the data width is `ovr_data` and the fetch width is `ovr_fetch`.
- R5: `stack_bytes` is 3 when the data width is wide and 2 when it is paged.
- R6: A clock edge with `retire` = 1, `flow_op` set to call (1), return (2) or restart (3), and a fetch width of 1 leaves `long_mode` at 1 afterwards.
- R7: On every other clock edge, `long_mode` keeps its value. This covers `flow_op` = 0 (none), `retire` = 0, and a call, return or restart retired with a fetch width of 0.
- R8: While `rst_n` is low, `long_mode` is held at the parameter `RESET_LONG`, which defaults to 0.
- R9: The reserved access kind code 3 behaves exactly like a data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_valid | input | 1 | The current instruction carries its own width bits |
| ovr_data | input | 1 | Width for data and stack operands: 1 is wide, 0 is paged |
| ovr_fetch | input | 1 | Width for instruction fetches: 1 is wide, 0 is paged |
| lg_addr | input | 24 | Logical address from the core |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 reserved (treated as data) |
| page_reg | input | 8 | Page register used by the paged form |
| retire | input | 1 | The current instruction completes on this edge |
| flow_op | input | 2 | Kind of retiring instruction: 0 none, 1 call, 2 return, 3 restart |
| eff_addr | output | 24 | Physical bus address |
| stack_bytes | output | 2 | Bytes moved by one stack push or pop |
| long_mode | output | 1 | Persistent long-mode bit |

## Verification
The clocked assertions sample the combinational inputs on the rising edge, so they assume every input is settled and known at that edge and changes only between edges. The bench drives all inputs on the falling edge to meet this. The mode assertions also assume that `retire` and `flow_op` describe one instruction per cycle. Random stimulus keeps the rate of call, return and restart retirements low and reasserts reset between phases, so the paged-mode cases stay reachable after the mode has turned wide.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  // access kind codes
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_STACK = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // control-flow kind of the retiring instruction
  typedef enum logic [1:0] {
    FLOW_NONE = 2'd0,
    FLOW_CALL = 2'd1,
    FLOW_RET  = 2'd2,
    FLOW_RST  = 2'd3
  } flow_op_e;
endpackage

// File: rtl/eaddr_width_sel.sv
module eaddr_width_sel
  import eaddr_pkg::*;
(
  input  logic       long_mode,
  input  logic       ovr_valid,
  input  logic       ovr_data,
  input  logic       ovr_fetch,
  input  logic [1:0] acc_kind,
  output logic       data_long,
  output logic       fetch_long,
  output logic       access_long
);
  // R4: overrides fall back to the persistent mode
  assign data_long  = ovr_valid ? ovr_data  : long_mode;
  assign fetch_long = ovr_valid ? ovr_fetch : long_mode;

  // R3 / R9: fetch uses fetch width, everything else uses data width
  always_comb begin
    unique case (acc_kind)
      ACC_FETCH: access_long = fetch_long;
      default:   access_long = data_long;
    endcase
  end
endmodule

// File: rtl/eaddr_former.sv
module eaddr_former #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic                 wide,
  input  logic                 data_long,
  input  logic [ADDR_W-1:0]    lg_addr,
  input  logic [ADDR_W-OFF_W-1:0] page_reg,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic [$clog2(ADDR_W/8+1)-1:0] stack_bytes
);
  localparam int PAGE_W      = ADDR_W - OFF_W;
  localparam int LONG_BYTES  = ADDR_W / 8;
  localparam int SHORT_BYTES = OFF_W / 8;
  localparam int SB_W        = $clog2(LONG_BYTES + 1);

  // R1 / R2: address formation
  function automatic logic [ADDR_W-1:0] form_addr(
    input logic              w,
    input logic [PAGE_W-1:0] pg,
    input logic [ADDR_W-1:0] a
  );
    if (w) return a;
    return {pg, a[OFF_W-1:0]};
  endfunction

  // R5: bytes per stack transfer
  function automatic logic [SB_W-1:0] xfer_bytes(input logic w);
    return w ? SB_W'(LONG_BYTES) : SB_W'(SHORT_BYTES);
  endfunction

  assign eff_addr    = form_addr(wide, page_reg, lg_addr);
  assign stack_bytes = xfer_bytes(data_long);
endmodule

// File: rtl/eaddr_mode_reg.sv
module eaddr_mode_reg
  import eaddr_pkg::*;
#(
  parameter bit RESET_LONG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retire,
  input  logic [1:0] flow_op,
  input  logic       fetch_long,
  output logic       long_mode
);
  logic is_flow;
  logic mode_set;

  assign is_flow  = (flow_op != FLOW_NONE);
  assign mode_set = retire && is_flow && fetch_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        long_mode <= RESET_LONG;
    else if (mode_set) long_mode <= fetch_long;
  end

  // R6: wide call/return/restart leaves mode wide
  a_r6_flow_sets_long: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (flow_op != 2'd0) && fetch_long) |=> long_mode);

  // R7: no qualifying retirement, mode holds
  a_r7_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && (flow_op != 2'd0) && fetch_long) |=> (long_mode == $past(long_mode)));
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
  import eaddr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int OFF_W      = 16,
  parameter bit RESET_LONG = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ovr_valid,
  input  logic                        ovr_data,
  input  logic                        ovr_fetch,
  input  logic [ADDR_W-1:0]           lg_addr,
  input  logic [1:0]                  acc_kind,
  input  logic [ADDR_W-OFF_W-1:0]     page_reg,
  input  logic                        retire,
  input  logic [1:0]                  flow_op,
  output logic [ADDR_W-1:0]           eff_addr,
  output logic [$clog2(ADDR_W/8+1)-1:0] stack_bytes,
  output logic                        long_mode
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  // named internal events for the assertions
  logic data_long;
  logic fetch_long;
  logic access_long;

  eaddr_width_sel u_width_sel (
    .long_mode  (long_mode),
    .ovr_valid  (ovr_valid),
    .ovr_data   (ovr_data),
    .ovr_fetch  (ovr_fetch),
    .acc_kind   (acc_kind),
    .data_long  (data_long),
    .fetch_long (fetch_long),
    .access_long(access_long)
  );

  eaddr_former #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_former (
    .wide       (access_long),
    .data_long  (data_long),
    .lg_addr    (lg_addr),
    .page_reg   (page_reg),
    .eff_addr   (eff_addr),
    .stack_bytes(stack_bytes)
  );

  eaddr_mode_reg #(.RESET_LONG(RESET_LONG)) u_mode_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .flow_op   (flow_op),
    .fetch_long(fetch_long),
    .long_mode (long_mode)
  );

  // R1: wide access passes the logical address through
  a_r1_wide_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    access_long |-> (eff_addr == lg_addr));

  // R2: paged access takes its top byte from the page register
  a_r2_paged_top: assert property (@(posedge clk) disable iff (!rst_n)
    !access_long |-> (eff_addr[ADDR_W-1:OFF_W] == page_reg &&
                      eff_addr[OFF_W-1:0] == lg_addr[OFF_W-1:0]));

  // R4: without override both widths follow the register
  a_r4_default_width: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_valid |-> (data_long == long_mode && fetch_long == long_mode));

  // R5: stack count is always one of the two legal sizes
  a_r5_stack_size: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_bytes == 2'(ADDR_W/8)) || (stack_bytes == 2'(OFF_W/8)));

  // R8: reset value
  always @(posedge clk) begin
    if (!rst_n) a_r8_reset_mode: assert (long_mode == RESET_LONG);
  end

  logic unused_pw;
  assign unused_pw = (PAGE_W == 0);
endmodule

// File: tb/eaddr_unit_bench.sv
module eaddr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovr_valid = 1'b0, ovr_data = 1'b0, ovr_fetch = 1'b0;
  logic [23:0] lg_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [7:0]  page_reg = '0;
  logic        retire = 1'b0;
  logic [1:0]  flow_op = '0;
  logic [23:0] eff_addr;
  logic [1:0]  stack_bytes;
  logic        long_mode;

  int checks = 0;
  int fails  = 0;
  bit mode_m = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eaddr_unit u_eaddr_unit (
    .clk(clk), .rst_n(rst_n), .ovr_valid(ovr_valid), .ovr_data(ovr_data),
    .ovr_fetch(ovr_fetch), .lg_addr(lg_addr), .acc_kind(acc_kind),
    .page_reg(page_reg), .retire(retire), .flow_op(flow_op),
    .eff_addr(eff_addr), .stack_bytes(stack_bytes), .long_mode(long_mode)
  );

  // reference: width for this access (R3, R4, R9)
  function automatic bit ref_width(bit mode, bit ov, bit od, bit of_, logic [1:0] k);
    bit dw = ov ? od : mode;
    bit fw = ov ? of_ : mode;
    return (k == 2'd0) ? fw : dw;
  endfunction

  // reference: address (R1, R2)
  function automatic logic [23:0] ref_addr(bit w, logic [7:0] pg, logic [23:0] a);
    logic [23:0] r;
    r = ({16'h0, pg} << 16) | (a & 24'h00FFFF);
    return w ? a : r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive on falling edge, check outputs, then register update
  task automatic step(bit ov, bit od, bit of_, logic [23:0] a, logic [1:0] k,
                      logic [7:0] pg, bit rt, logic [1:0] fo, string req);
    bit w, dw, fw;
    @(negedge clk);
    ovr_valid = ov; ovr_data = od; ovr_fetch = of_; lg_addr = a;
    acc_kind = k; page_reg = pg; retire = rt; flow_op = fo;
    #1;
    w  = ref_width(mode_m, ov, od, of_, k);
    dw = ov ? od : mode_m;
    fw = ov ? of_ : mode_m;
    check({req, " addr"}, 32'(eff_addr), 32'(ref_addr(w, pg, a)));
    check({req, " R5 bytes"}, 32'(stack_bytes), dw ? 32'd3 : 32'd2);
    if (rt && fo != 2'd0 && fw) mode_m = 1'b1;
    @(posedge clk); #1;
    check({req, " R6/R7 mode"}, 32'(long_mode), 32'(mode_m));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; retire = 1'b0; flow_op = 2'd0;
    @(posedge clk); #1;
    check("R8 reset", 32'(long_mode), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mode_m = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2: paged, upper logical byte ignored
    step(0, 0, 0, 24'hAB1234, 2'd1, 8'h5C, 0, 2'd0, "R2 paged data");
    step(0, 0, 0, 24'h001234, 2'd1, 8'h5C, 0, 2'd0, "R2 upper ignored");
    // R9: reserved kind acts as data
    step(1, 1, 0, 24'hCD9876, 2'd3, 8'h11, 0, 2'd0, "R9 reserved wide");
    step(1, 0, 1, 24'hCD9876, 2'd3, 8'h11, 0, 2'd0, "R9 reserved paged");
    // R3: fetch uses fetch width, stack uses data width
    step(1, 0, 1, 24'h7F0001, 2'd0, 8'h22, 0, 2'd0, "R3 fetch wide");
    step(1, 1, 0, 24'h7F0001, 2'd2, 8'h22, 0, 2'd0, "R3 stack wide");
    // R7: paged-fetch call does not change mode; non-retire ignored
    step(1, 1, 0, 24'h000100, 2'd0, 8'h00, 1, 2'd1, "R7 paged call");
    step(1, 0, 1, 24'h000100, 2'd0, 8'h00, 0, 2'd1, "R7 no retire");
    step(1, 0, 1, 24'h000100, 2'd0, 8'h00, 1, 2'd0, "R7 flow none");
    // R6: wide restart sets mode
    step(1, 0, 1, 24'h000038, 2'd0, 8'h00, 1, 2'd3, "R6 wide restart");
    // R4/R1: default widths now wide
    step(0, 0, 0, 24'hFEDCBA, 2'd1, 8'h33, 0, 2'd0, "R4 R1 default wide");
    step(0, 0, 0, 24'hFEDCBA, 2'd2, 8'h33, 0, 2'd0, "R4 stack default");
    do_reset();
    step(1, 0, 1, 24'h123456, 2'd0, 8'h44, 1, 2'd2, "R6 wide return");
    do_reset();
    step(1, 0, 1, 24'h123456, 2'd0, 8'h44, 1, 2'd1, "R6 wide call");
    // constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      do_reset();
      for (int i = 0; i < 60; i++) begin
        bit rt = ($urandom % 8) == 0;
        step(bit'($urandom), bit'($urandom), bit'($urandom), 24'($urandom),
             2'($urandom), 8'($urandom), rt, 2'($urandom), "R1-R9 random");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule